// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Controller

This block is the digital supervisor that sits beside one channel of a switching regulator. Once per switching cycle it receives a start-of-cycle pulse. Alongside that it receives the output of a peak overcurrent comparator and the output of a reverse-current (negative overcurrent) comparator. When the peak comparator fires, the block removes high-side drive at once and keeps it removed until the next cycle starts. It also counts how many cycles in a row have tripped.

A run of tripped cycles reaching a programmable limit is treated as a hard fault. The controller parks the power stage and then waits a programmable number of soft-start periods, counted as pulses from the soft-start timer. After that wait it clears its counters and asks for a fresh soft-start, which gives hiccup-mode retry. A reverse-current trip follows a separate path. Switching stops, the stage is asked to go high-impedance, and the output is pulled down until a comparator reports that it is back in regulation. The channel then restarts. The analog comparators, thresholds and current sensing stay outside this block.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While running, `hs_gate_en` drops in the same cycle that `oc_flag` is high. It stays low for the rest of that switching cycle and returns high only after the next clock edge that samples `cyc_start` high.
- R2: The first overcurrent detection after a clean history sets the consecutive count to 1 and raises `oc_cond_flag` on the following clock edge.
- R3: Each further switching cycle that contains an overcurrent detection adds one to the count. When a switching cycle ends without a detection, the count is cleared at the next `cyc_start` edge and `oc_cond_flag` falls. Any run shorter than FAULT_LIMIT therefore never faults.
- R4: When FAULT_LIMIT consecutive cycles (default 17) have tripped, the controller enters the fault state. `fault_flag` is high and `hs_gate_en` is low, and `oc_flag` is ignored there.
- R5: In the fault state the controller counts `ss_done` pulses. On the HICCUP_SS-th pulse (default 4) it returns to running, with the count cleared and `oc_cond_flag` low, and pulses `ss_restart_req` high for exactly one cycle. Fewer pulses keep it in fault. `ss_done` has no effect while running.
- R6: While running, a high `neg_oc_flag` moves the controller to a reverse-current state on the next edge. In that state `hs_gate_en` is low and `tristate_req` and `discharge_req` are high. It stays there until `in_reg` is high, then returns to running with a one-cycle `ss_restart_req`.
- R7: With `en` low, the next edge puts the controller in the idle state. All outputs are low and the count is cleared. While idle, `oc_flag` has no effect. Raising `en` starts running with a one-cycle `ss_restart_req`.
- R8: A synchronous active-low reset leaves every output low and the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Channel enable |
| cyc_start | input | 1 | One-clock pulse at the start of each switching cycle |
| oc_flag | input | 1 | Peak overcurrent comparator output |
| neg_oc_flag | input | 1 | Reverse-current comparator output |
| in_reg | input | 1 | Output has returned to its regulation level |
| ss_done | input | 1 | One-clock pulse at the end of each soft-start period |
| hs_gate_en | output | 1 | Permission to turn on the high-side switch |
| tristate_req | output | 1 | Request to put the power stage in high impedance |
| discharge_req | output | 1 | Request to switch on the output pull-down |
| fault_flag | output | 1 | Overcurrent fault state (hiccup wait) |
| oc_cond_flag | output | 1 | A run of tripped cycles is in progress |
| ss_restart_req | output | 1 | One-cycle request to begin a soft-start |

## Verification
The hardest situation to reach is the exact edge of the fault limit. The run must be one trip short of the limit and then exactly at it, with no clean cycle slipped in between. After that comes the last of the hiccup-wait pulses. Each scenario task drives whole switching cycles of three clocks, with the trip placed mid-cycle. It replays 16 tripped cycles followed by clean ones, and then 17, so both sides of the limit are seen. In the fault state it feeds soft-start pulses one at a time and checks that only the fourth releases the channel. A second run of 16 trips then shows that the count really restarted from zero.

// File: rtl/ocp_pkg.sv
// Package: shared types for the overcurrent hiccup controller.
// Assumes: four controller states, encoded in two bits.
package ocp_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2,
        ST_NEG   = 2'd3
    } ocp_state_e;
endpackage

// File: rtl/ocp_blank.sv
// Module: ocp_blank
// Keeps high-side drive blanked for the rest of a switching cycle
// once an overcurrent trip has been seen in it.
// Assumes: oc_in is already qualified by the running state; a trip in
// the same clock as cyc_start belongs to the new cycle.
module ocp_blank (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_start,
    input  logic oc_in,
    output logic blank_q
);
    // Purpose: set on a trip, clear at the next cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            blank_q <= 1'b0;
        else if (oc_in)
            blank_q <= 1'b1;
        else if (cyc_start)
            blank_q <= 1'b0;
    end

    a_r1_blank_sets : assert property (@(posedge clk) disable iff (!rst_n)
        (en && oc_in) |=> blank_q);
endmodule

// File: rtl/ocp_cnt.sv
// Module: ocp_cnt
// Counts consecutive switching cycles that contained an overcurrent
// trip, saturating at LIMIT, and keeps the condition flag.
// Assumes: blank_q reports whether the current cycle has tripped; the
// count is frozen whenever act is low.
module ocp_cnt #(
    parameter int LIMIT = 17,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          act,
    input  logic          cyc_start,
    input  logic          oc_in,
    input  logic          blank_q,
    output logic [CW-1:0] cnt_q,
    output logic          cond_q,
    output logic          hit
);
    logic [CW-1:0] base;
    logic [CW-1:0] cnt_nxt;

    // Purpose: work out the next count from cycle boundaries and trips.
    always_comb begin
        base = (cyc_start && !blank_q) ? '0 : cnt_q;
        if (oc_in && (cyc_start || !blank_q) && (base < CW'(LIMIT)))
            base = base + 1'b1;
        if (clr)
            cnt_nxt = '0;
        else if (act)
            cnt_nxt = base;
        else
            cnt_nxt = cnt_q;
    end

    // Purpose: register the count and the condition flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cond_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            cond_q <= (cnt_nxt != '0);
        end
    end

    assign hit = (cnt_q == CW'(LIMIT));

    a_r4_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));
    a_r2_first_trip : assert property (@(posedge clk) disable iff (!rst_n)
        (act && !clr && !cyc_start && oc_in && !blank_q && cnt_q == '0)
        |=> (cnt_q == CW'(1) && cond_q));
    a_r3_clean_clears : assert property (@(posedge clk) disable iff (!rst_n)
        (act && cyc_start && !blank_q && !oc_in) |=> (cnt_q == '0 && !cond_q));
endmodule

// File: rtl/ocp_seq.sv
// Module: ocp_seq
// Channel sequencer: idle, running, hiccup fault wait and reverse-current
// recovery. Counts soft-start periods during the fault wait.
// Assumes: ss_done is a one-clock pulse; WAIT_SS is at least 1.
module ocp_seq
    import ocp_pkg::*;
#(
    parameter int WAIT_SS = 4,
    localparam int WW = $clog2(WAIT_SS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       hit,
    input  logic       ss_done,
    input  logic       neg_oc,
    input  logic       in_reg,
    output ocp_state_e state_q,
    output logic       restart_q,
    output logic       clr_cnt
);
    ocp_state_e    st_nxt;
    logic          restart_nxt;
    logic [WW-1:0] wait_q;
    logic          wait_last;

    assign wait_last = ss_done && (wait_q == WW'(WAIT_SS - 1));

    // Purpose: choose the next state, restart pulse and count clear.
    always_comb begin
        st_nxt      = state_q;
        restart_nxt = 1'b0;
        clr_cnt     = 1'b0;
        if (!en) begin
            st_nxt  = ST_OFF;
            clr_cnt = 1'b1;
        end else begin
            case (state_q)
                ST_OFF: begin
                    st_nxt      = ST_RUN;
                    restart_nxt = 1'b1;
                end
                ST_RUN: begin
                    if (hit)
                        st_nxt = ST_FAULT;
                    else if (neg_oc)
                        st_nxt = ST_NEG;
                end
                ST_FAULT: begin
                    if (wait_last) begin
                        st_nxt      = ST_RUN;
                        restart_nxt = 1'b1;
                        clr_cnt     = 1'b1;
                    end
                end
                ST_NEG: begin
                    if (in_reg) begin
                        st_nxt      = ST_RUN;
                        restart_nxt = 1'b1;
                    end
                end
                default: st_nxt = ST_OFF;
            endcase
        end
    end

    // Purpose: hold state and the one-cycle restart request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            restart_q <= 1'b0;
        end else begin
            state_q   <= st_nxt;
            restart_q <= restart_nxt;
        end
    end

    // Purpose: count soft-start periods while waiting in fault.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_FAULT || !en)
            wait_q <= '0;
        else if (ss_done && !wait_last)
            wait_q <= wait_q + 1'b1;
    end

    a_r5_fault_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && en && !ss_done) |=> state_q == ST_FAULT);
    a_r6_neg_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NEG && en && !in_reg) |=> state_q == ST_NEG);
    a_r7_disable_idle : assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_OFF && !restart_q));
    a_r5_restart_single : assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |=> !restart_q);
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
// Module: ocp_hiccup_ctrl (top)
// Per-channel overcurrent supervisor: cycle blanking, consecutive trip
// counting, hiccup retry timed in soft-start periods, and the
// reverse-current high-impedance/discharge path.
// Assumes: cyc_start and ss_done are one-clock pulses; comparator flags
// are already synchronous to clk.
module ocp_hiccup_ctrl
    import ocp_pkg::*;
#(
    parameter int FAULT_LIMIT = 17,
    parameter int HICCUP_SS   = 4,
    localparam int CW = $clog2(FAULT_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_start,
    input  logic oc_flag,
    input  logic neg_oc_flag,
    input  logic in_reg,
    input  logic ss_done,
    output logic hs_gate_en,
    output logic tristate_req,
    output logic discharge_req,
    output logic fault_flag,
    output logic oc_cond_flag,
    output logic ss_restart_req
);
    ocp_state_e    state;
    logic          running;
    logic          oc_run;
    logic          blank_q;
    logic [CW-1:0] cnt;
    logic          hit;
    logic          clr_cnt;

    assign running = (state == ST_RUN);
    assign oc_run  = oc_flag && running;

    ocp_blank u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cyc_start (cyc_start),
        .oc_in     (oc_run),
        .blank_q   (blank_q)
    );

    ocp_cnt #(.LIMIT(FAULT_LIMIT)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_cnt),
        .act       (running),
        .cyc_start (cyc_start),
        .oc_in     (oc_run),
        .blank_q   (blank_q),
        .cnt_q     (cnt),
        .cond_q    (oc_cond_flag),
        .hit       (hit)
    );

    ocp_seq #(.WAIT_SS(HICCUP_SS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .hit       (hit),
        .ss_done   (ss_done),
        .neg_oc    (neg_oc_flag),
        .in_reg    (in_reg),
        .state_q   (state),
        .restart_q (ss_restart_req),
        .clr_cnt   (clr_cnt)
    );

    // Purpose: derive the drive-side outputs from state and blanking.
    always_comb begin
        hs_gate_en    = running && !blank_q && !oc_flag;
        tristate_req  = (state == ST_NEG);
        discharge_req = (state == ST_NEG);
        fault_flag    = (state == ST_FAULT);
    end

    a_r1_off_rest_of_cycle : assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && running) |=> !hs_gate_en);
    a_r6_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hs_gate_en, tristate_req, fault_flag}));
    a_r4_fault_gate_off : assert property (@(posedge clk) disable iff (!rst_n)
        (running && hit) |=> !hs_gate_en);
endmodule

// File: tb/ocp_hiccup_ctrl_tb_top.sv
// Bench: directed scenarios, one task each, each checking its own results.
module ocp_hiccup_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic cyc_start = 1'b0;
    logic oc_flag = 1'b0;
    logic neg_oc_flag = 1'b0;
    logic in_reg = 1'b0;
    logic ss_done = 1'b0;
    logic hs_gate_en, tristate_req, discharge_req, fault_flag, oc_cond_flag, ss_restart_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    ocp_hiccup_ctrl #(.FAULT_LIMIT(17), .HICCUP_SS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cyc_start(cyc_start),
        .oc_flag(oc_flag), .neg_oc_flag(neg_oc_flag), .in_reg(in_reg),
        .ss_done(ss_done), .hs_gate_en(hs_gate_en), .tristate_req(tristate_req),
        .discharge_req(discharge_req), .fault_flag(fault_flag),
        .oc_cond_flag(oc_cond_flag), .ss_restart_req(ss_restart_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One switching cycle of three clocks; trip (if any) on the second clock.
    task automatic sw_cycle(input logic trip, input logic in_run);
        cyc_start = 1'b1; oc_flag = 1'b0; tick();
        cyc_start = 1'b0; oc_flag = trip; #1;
        if (trip && in_run) chk("R1", "gate off same cycle as trip", hs_gate_en, 1'b0);
        tick();
        oc_flag = 1'b0; #1;
        if (trip && in_run) chk("R1", "gate held off rest of cycle", hs_gate_en, 1'b0);
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0; tick(); tick();
        chk("R8", "reset gate", hs_gate_en, 1'b0);
        chk("R8", "reset fault", fault_flag, 1'b0);
        chk("R8", "reset cond", oc_cond_flag, 1'b0);
        chk("R8", "reset restart", ss_restart_req, 1'b0);
        chk("R8", "reset tristate", tristate_req, 1'b0);
        rst_n = 1'b1; tick();
        oc_flag = 1'b1; tick(); oc_flag = 1'b0; tick();
        chk("R7", "trip while idle ignored", oc_cond_flag, 1'b0);
        en = 1'b1; tick();
        chk("R7", "enable restart pulse", ss_restart_req, 1'b1);
        chk("R7", "enable gate on", hs_gate_en, 1'b1);
        tick();
        chk("R7", "restart pulse single", ss_restart_req, 1'b0);
    endtask

    task automatic t_single();
        sw_cycle(1'b1, 1'b1);
        chk("R2", "cond flag after first trip", oc_cond_flag, 1'b1);
        cyc_start = 1'b1; tick(); cyc_start = 1'b0; #1;
        chk("R1", "gate back at next cycle", hs_gate_en, 1'b1);
        tick(); tick();
        sw_cycle(1'b0, 1'b1);
        chk("R3", "cond cleared after clean cycle", oc_cond_flag, 1'b0);
    endtask

    task automatic t_below_limit();
        for (int i = 0; i < 16; i++) sw_cycle(1'b1, 1'b1);
        chk("R3", "no fault at limit-1", fault_flag, 1'b0);
        chk("R3", "cond held during run", oc_cond_flag, 1'b1);
        ss_done = 1'b1; tick(); ss_done = 1'b0; #1;
        chk("R5", "ss_done in run no fault", fault_flag, 1'b0);
        chk("R5", "ss_done in run no restart", ss_restart_req, 1'b0);
        sw_cycle(1'b0, 1'b1);
        sw_cycle(1'b0, 1'b1);
        chk("R3", "cond cleared after run", oc_cond_flag, 1'b0);
        chk("R3", "gate on after run", hs_gate_en, 1'b1);
    endtask

    task automatic t_fault_hiccup();
        for (int i = 0; i < 17; i++) sw_cycle(1'b1, 1'b1);
        chk("R4", "fault at limit", fault_flag, 1'b1);
        sw_cycle(1'b0, 1'b0);
        chk("R4", "gate off in fault", hs_gate_en, 1'b0);
        sw_cycle(1'b1, 1'b0);
        chk("R4", "trip ignored in fault", fault_flag, 1'b1);
        for (int i = 0; i < 3; i++) begin
            ss_done = 1'b1; tick(); ss_done = 1'b0; tick();
        end
        chk("R5", "still fault after 3 periods", fault_flag, 1'b1);
        chk("R5", "no restart before wait ends", ss_restart_req, 1'b0);
        ss_done = 1'b1; tick(); ss_done = 1'b0; #1;
        chk("R5", "fault released", fault_flag, 1'b0);
        chk("R5", "restart pulse", ss_restart_req, 1'b1);
        chk("R5", "cond cleared at release", oc_cond_flag, 1'b0);
        chk("R5", "gate on after release", hs_gate_en, 1'b1);
        tick();
        chk("R5", "restart single cycle", ss_restart_req, 1'b0);
        for (int i = 0; i < 16; i++) sw_cycle(1'b1, 1'b1);
        chk("R5", "count restarted from zero", fault_flag, 1'b0);
        sw_cycle(1'b0, 1'b1);
        sw_cycle(1'b0, 1'b1);
    endtask

    task automatic t_neg();
        neg_oc_flag = 1'b1; tick(); neg_oc_flag = 1'b0; #1;
        chk("R6", "tristate requested", tristate_req, 1'b1);
        chk("R6", "discharge requested", discharge_req, 1'b1);
        chk("R6", "gate off", hs_gate_en, 1'b0);
        tick(); tick(); tick();
        chk("R6", "held until regulation", tristate_req, 1'b1);
        in_reg = 1'b1; tick(); in_reg = 1'b0; #1;
        chk("R6", "tristate released", tristate_req, 1'b0);
        chk("R6", "discharge released", discharge_req, 1'b0);
        chk("R6", "restart after recovery", ss_restart_req, 1'b1);
        chk("R6", "gate on after recovery", hs_gate_en, 1'b1);
        tick();
    endtask

    task automatic t_disable();
        for (int i = 0; i < 3; i++) sw_cycle(1'b1, 1'b1);
        chk("R7", "cond before disable", oc_cond_flag, 1'b1);
        en = 1'b0; tick();
        chk("R7", "cond cleared on disable", oc_cond_flag, 1'b0);
        chk("R7", "gate off on disable", hs_gate_en, 1'b0);
        for (int i = 0; i < 17; i++) sw_cycle(1'b1, 1'b0);
        chk("R7", "no fault while disabled", fault_flag, 1'b0);
        en = 1'b1; tick();
        chk("R7", "re-enable restart", ss_restart_req, 1'b1);
        for (int i = 0; i < 17; i++) sw_cycle(1'b1, 1'b1);
        chk("R4", "fault again", fault_flag, 1'b1);
        en = 1'b0; tick();
        chk("R7", "disable leaves fault", fault_flag, 1'b0);
        en = 1'b1; tick(); tick();
        rst_n = 1'b0; tick();
        chk("R8", "reset mid-run gate", hs_gate_en, 1'b0);
        chk("R8", "reset mid-run cond", oc_cond_flag, 1'b0);
        rst_n = 1'b1; tick();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        tick();
        t_reset();
        t_single();
        t_below_limit();
        t_fault_hiccup();
        t_neg();
        t_disable();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule